// File: doc/BRIEF.md
# DMA Channel Bus-Mode Arbiter

This block decides which of several DMA channels owns each transfer slot on a shared internal bus, and when the bus goes back to the CPU. Each channel presents a request level and a mode bit. The mode bit selects burst operation, where the channel keeps the bus unit after unit, or cycle-steal operation, where the channel takes one transfer unit per grant. The bus sequencer pulses a strobe each time the granted channel finishes a transfer unit. With that strobe it also flags whether the unit was the channel's last one.

Arbitration happens only at transfer-unit boundaries, or on any cycle while the CPU holds the bus. The default order is fixed, with lower channel numbers winning. A higher channel preempts a burst at the next boundary. A cycle-steal channel gives way after every unit, so it interleaves with a lower-priority burst channel and the bus is not released between them. The bus returns to the CPU only when no channel is left eligible. An optional rotating order moves the channel just served to the lowest priority.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, `grant` is all zero, `dmaOwnsBus` is 0, and the rotation pointer names channel 0.
- R2: At most one `grant` bit is high in any cycle. `dmaOwnsBus` is 1 exactly when one grant bit is high.
- R3: While the bus is held, `grant` changes only on the cycle after a cycle with `unitDone` high. While the CPU holds the bus, an eligible request is granted on the next cycle, and `unitDone` has no effect.
- R4: With `rrEnable` = 0, each decision grants the lowest-numbered eligible channel. This preempts a lower channel's burst at its next unit boundary.
- R5: A burst channel (`burstMode` bit = 1) that wins keeps the grant until its last unit completes. A preempted lower burst channel then resumes without a CPU cycle in between.
- R6: A cycle-steal channel (`burstMode` bit = 0) receives exactly one unit per grant. Paired with a lower-priority burst channel, the grants alternate channel 1, channel 0, channel 1, channel 0, with the bus held throughout.
- R7: A cycle-steal channel requesting alone leaves `dmaOwnsBus` low for exactly one cycle after each unit, and is then granted again.
- R8: When a unit of a burst channel finishes while that channel still requests and `chanDone` is low, `dmaOwnsBus` stays high on the next cycle.
- R9: With `rrEnable` = 1, the channel just granted becomes the lowest priority. The search starts at the channel after it, wrapping from the top channel to channel 0.
- R10: A channel whose `chanDone` bit is high together with `unitDone` while it is granted is left out of that decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | NUM_CH | Per-channel transfer request level |
| burstMode | input | NUM_CH | Per-channel mode: 1 burst, 0 cycle steal |
| chanDone | input | NUM_CH | Per-channel last-unit flag, valid with `unitDone` |
| unitDone | input | 1 | Granted channel finished one transfer unit |
| rrEnable | input | 1 | 1 selects rotating order, 0 selects fixed order |
| grant | output | NUM_CH | One-hot grant of the current transfer slot |
| dmaOwnsBus | output | 1 | 1 while the DMA side holds the bus, 0 when released to the CPU |

## Verification
The checker watches, on every cycle, the properties that hold for any stimulus: the one-hot grant and its agreement with bus ownership, a stable grant between unit boundaries, a cycle-steal channel giving way after each unit, a continuing burst keeping the bus, and channel 0 winning from idle in fixed order. Other behaviours depend on a whole history, and only the bench's scenarios show them. These are the 1-0-1-0 interleave pattern, a suspended burst resuming after the higher channel finishes, the single released cycle between lone cycle-steal units, the rotating order, and the pointer returning to channel 0 on reset.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Strobes from the control side to the grant datapath.
  typedef struct packed {
    logic decide;      // load a new grant this cycle
    logic advancePtr;  // move the rotation pointer past the winner
  } arbStrobes_t;

  typedef enum logic {
    BUS_CPU = 1'b0,
    BUS_DMA = 1'b1
  } busOwner_e;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        unitDone,
  input  logic        rrEnable,
  input  logic        winnerValid,
  output arbStrobes_t strobes,
  output logic        dmaOwnsBus
);

  busOwner_e ownerQ;

  // A decision is taken at every unit boundary, or on any cycle while idle.
  always_comb begin
    strobes.decide     = (ownerQ == BUS_CPU) || unitDone;
    strobes.advancePtr = strobes.decide && rrEnable && winnerValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= BUS_CPU;
    end else if (strobes.decide) begin
      ownerQ <= winnerValid ? BUS_DMA : BUS_CPU;
    end
  end

  assign dmaOwnsBus = (ownerQ == BUS_DMA);

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] burstMode,
  input  logic [NUM_CH-1:0] chanDone,
  input  logic              unitDone,
  input  logic              rrEnable,
  input  arbStrobes_t       strobes,
  output logic              winnerValid,
  output logic [NUM_CH-1:0] grant
);

  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] grantQ;
  logic [NUM_CH-1:0] dropMask;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] winner;
  logic [PTR_W-1:0]  ptrQ;
  logic [PTR_W-1:0]  basePtr;
  logic [PTR_W-1:0]  winIdx;

  function automatic logic [PTR_W-1:0] wrapIdx(input logic [PTR_W-1:0] base, input int offset);
    int sum;
    sum = int'(base) + offset;
    if (sum >= NUM_CH) sum = sum - NUM_CH;
    return PTR_W'(sum);
  endfunction

  // A channel finishing its last unit, or a cycle-steal channel that has
  // just used its single unit, sits out the current decision.
  always_comb begin
    dropMask = grantQ & {NUM_CH{unitDone}} & (chanDone | ~burstMode);
    eligible = reqIn & ~dropMask;
  end

  // Search from the base position: channel 0 in fixed order, pointer in rotation.
  always_comb begin
    basePtr     = rrEnable ? ptrQ : '0;
    winnerValid = 1'b0;
    winIdx      = '0;
    for (int off = 0; off < NUM_CH; off++) begin
      if (!winnerValid && eligible[wrapIdx(basePtr, off)]) begin
        winnerValid = 1'b1;
        winIdx      = wrapIdx(basePtr, off);
      end
    end
    winner = winnerValid ? (NUM_CH'(1) << winIdx) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= '0;
      ptrQ   <= '0;
    end else begin
      if (strobes.decide)     grantQ <= winner;
      if (strobes.advancePtr) ptrQ   <= wrapIdx(winIdx, 1);
    end
  end

  assign grant = grantQ;

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] burstMode,
  input  logic [NUM_CH-1:0] chanDone,
  input  logic              unitDone,
  input  logic              rrEnable,
  output logic [NUM_CH-1:0] grant,
  output logic              dmaOwnsBus
);

  arbStrobes_t strobes;
  logic        winnerValid;

  arb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .unitDone   (unitDone),
    .rrEnable   (rrEnable),
    .winnerValid(winnerValid),
    .strobes    (strobes),
    .dmaOwnsBus (dmaOwnsBus)
  );

  arb_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .burstMode  (burstMode),
    .chanDone   (chanDone),
    .unitDone   (unitDone),
    .rrEnable   (rrEnable),
    .strobes    (strobes),
    .winnerValid(winnerValid),
    .grant      (grant)
  );

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] reqIn,
  input logic [NUM_CH-1:0] burstMode,
  input logic [NUM_CH-1:0] chanDone,
  input logic              unitDone,
  input logic              rrEnable,
  input logic [NUM_CH-1:0] grant,
  input logic              dmaOwnsBus
);

  logic burstGoesOn;
  logic stealUnitEnds;
  assign burstGoesOn   = unitDone && ((grant & burstMode & reqIn & ~chanDone) != '0);
  assign stealUnitEnds = unitDone && ((grant & ~burstMode) != '0);

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  a_r2_owner_matches: assert property (@(posedge clk) disable iff (!rstN)
    dmaOwnsBus == (grant != '0));

  a_r3_hold_between_units: assert property (@(posedge clk) disable iff (!rstN)
    (dmaOwnsBus && !unitDone) |=> (grant == $past(grant)));

  a_r4_ch0_wins_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaOwnsBus && !rrEnable && reqIn[0]) |=> grant[0]);

  a_r6_steal_yields: assert property (@(posedge clk) disable iff (!rstN)
    stealUnitEnds |=> (grant != $past(grant)));

  a_r8_burst_keeps_bus: assert property (@(posedge clk) disable iff (!rstN)
    burstGoesOn |=> dmaOwnsBus);

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqIn     (reqIn),
  .burstMode (burstMode),
  .chanDone  (chanDone),
  .unitDone  (unitDone),
  .rrEnable  (rrEnable),
  .grant     (grant),
  .dmaOwnsBus(dmaOwnsBus)
);

// File: tb/test_dma_bus_arbiter.sv
module test_dma_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int NVEC = 23;

  // Entry: {reqIn[1:0], burstMode[1:0], rrEnable, unitDone, chanDone[1:0], expected grant[1:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b00_11_0_0_00_00, // 1  R3 idle, nothing requested
    10'b10_11_0_0_00_10, // 2  R3 idle request granted next cycle
    10'b10_11_0_0_00_10, // 3  R3 hold
    10'b11_11_0_0_00_10, // 4  R3 ch0 arrives mid unit, no change
    10'b11_11_0_1_00_01, // 5  R4 preempt at boundary
    10'b11_11_0_1_00_01, // 6  R5 ch0 burst continues
    10'b11_11_0_1_01_10, // 7  R5 R10 ch0 finished, ch1 resumes
    10'b10_11_0_0_00_10, // 8  R5 ch1 holds
    10'b11_10_0_1_00_01, // 9  R4 cycle-steal ch0 takes slot
    10'b11_10_0_1_00_10, // 10 R6 back to ch1, bus kept
    10'b11_10_0_1_00_01, // 11 R6 alternation
    10'b11_10_0_1_00_10, // 12 R6 R8 alternation
    10'b11_10_0_1_10_01, // 13 R10 ch1 last unit, ch0 left
    10'b01_10_0_1_00_00, // 14 R7 lone steal releases bus
    10'b01_10_0_0_00_01, // 15 R7 regranted after one cycle
    10'b01_10_0_1_01_00, // 16 R10 last unit, released
    10'b00_10_0_1_00_00, // 17 R3 unitDone while idle ignored
    10'b11_11_1_0_00_01, // 18 R9 rotation starts at ch0
    10'b11_11_1_1_00_10, // 19 R9 ch0 served, ch1 next
    10'b11_11_1_1_00_01, // 20 R9 wrap to ch0
    10'b11_11_1_1_00_10, // 21 R9
    10'b11_11_1_1_10_01, // 22 R9 R10 ch1 done
    10'b01_11_1_1_01_00  // 23 R10 all done, released
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] reqIn = '0;
  logic [NCH-1:0] burstMode = '0;
  logic [NCH-1:0] chanDone = '0;
  logic           unitDone = 1'b0;
  logic           rrEnable = 1'b0;
  logic [NCH-1:0] grant;
  logic           dmaOwnsBus;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_arbiter #(.NUM_CH(NCH)) i_dma_bus_arbiter (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .burstMode (burstMode),
    .chanDone  (chanDone),
    .unitDone  (unitDone),
    .rrEnable  (rrEnable),
    .grant     (grant),
    .dmaOwnsBus(dmaOwnsBus)
  );

  task automatic checkOut(input string tag, input logic [NCH-1:0] expGrant);
    applied++;
    if (grant !== expGrant || dmaOwnsBus !== (expGrant != '0)) begin
      miscompares++;
      $display("FAIL %s: grant=%b dmaOwnsBus=%b expected grant=%b dmaOwnsBus=%b",
               tag, grant, dmaOwnsBus, expGrant, (expGrant != '0));
    end
  endtask

  task automatic drive(input logic [9:0] v);
    reqIn     = v[9:8];
    burstMode = v[7:6];
    rrEnable  = v[5];
    unitDone  = v[4];
    chanDone  = v[3:2];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 reset state", 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after release", 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      checkOut($sformatf("R2 R3 vector %0d", i + 1), VEC[i][1:0]);
    end

    // Rotation pointer sits at ch1 here; a reset must bring it back to ch0.
    drive(10'b10_11_0_0_00_00);
    @(negedge clk);
    checkOut("R3 idle grant ch1", 2'b10);
    rstN = 1'b0;
    #1;
    checkOut("R1 reset while granted", 2'b00);
    @(negedge clk);
    drive(10'b11_11_1_0_00_00);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 R9 pointer back at ch0", 2'b01);
    drive(10'b11_11_1_1_00_00);
    @(negedge clk);
    checkOut("R9 rotates after reset", 2'b10);
    drive(10'b00_11_1_1_10_00);
    @(negedge clk);
    checkOut("R10 final release", 2'b00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule